// File: doc/BRIEF.md
# Serial Token Packet Generator with CRC5

This block builds low-speed serial-bus token packets and start-of-frame packets and sends them as a stream of single bits. The least significant bit of each field goes first. One request names the packet kind and carries a 7-bit device address, a 4-bit endpoint and an 11-bit frame number. The generator then sends four parts in order: a sync byte, a PID byte whose high nibble is the bitwise inverse of its low nibble, an 11-bit field, and a 5-bit check code. The check code is computed over the field bits while they leave the block. A packet is 32 bits long.

Both edges of the block are valid/ready streams. On the request side, `req_ready` is high only while no packet is in progress. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. On the bit side, a bit moves only on an edge where `bit_valid` and `bit_ready` are both high. While `bit_ready` is low, the line encoder downstream can hold the generator indefinitely, and the bit on offer stays unchanged. `bit_last` marks the final bit of the packet.

Top module: `tok_pkt_gen`

## Requirements
- R1: `req_ready` is high exactly while no packet is in progress. A request presented while a packet is being sent is ignored, and the packet in flight is not changed by it.
- R2: Transmitted bits 0 to 7 are the sync byte 80H, least significant bit first: seven zeros, then a one.
- R3: Transmitted bits 8 to 15 are the PID, least significant bit first. The low nibble is the kind code and the high nibble is its inverse. `req_kind` encoding is 0 = OUT (E1H), 1 = IN (69H), 2 = SETUP (2DH), 3 = SOF (A5H).
- R4: For OUT, IN and SETUP, bits 16 to 22 are the address and bits 23 to 26 are the endpoint, each least significant bit first.
- R5: For SOF, bits 16 to 26 are the frame number, least significant bit first. Address and endpoint have no effect.
- R6: Bits 27 to 31 carry the check code. It uses polynomial x^5+x^2+1, a register preset to 11111, and the 11 field bits in transmit order. The code sent is the inverted remainder, highest remainder bit first.
- R7: While `bit_valid` is high and `bit_ready` is low, `bit_data` and `bit_last` hold their values, and `bit_valid` stays high.
- R8: `bit_last` is high only on bit 31. In the cycle after that bit is accepted, `bit_valid` is low and `req_ready` is high.
- R9: `bit_valid` rises in the first cycle after a request is accepted, with bit 0 on offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator idle, request can be taken |
| req_kind | input | 2 | Packet kind (0 OUT, 1 IN, 2 SETUP, 3 SOF) |
| req_addr | input | 7 | Device address for token packets |
| req_endp | input | 4 | Endpoint for token packets |
| req_frame | input | 11 | Frame number for SOF packets |
| bit_valid | output | 1 | A bit is on offer |
| bit_data | output | 1 | Bit on offer |
| bit_last | output | 1 | Bit on offer is the final bit of the packet |
| bit_ready | input | 1 | Downstream takes the bit on this edge |

## Verification
A request accepted on one edge must show `bit_valid` with the sync bit at the next sample. Each bit on offer is due in the cycle after the previous one was accepted, and a bit that was refused must still be present at the next sample. The bench drives inputs and samples outputs on the falling edge. It records a bit only when it has itself raised `bit_ready` for the coming rising edge, so every recorded bit matches exactly one transfer. After the final transfer, the next falling-edge sample must show the block idle again.

// File: rtl/tokgen_pkg.sv
package tokgen_pkg;

  typedef enum logic [1:0] {
    KIND_OUT   = 2'd0,
    KIND_IN    = 2'd1,
    KIND_SETUP = 2'd2,
    KIND_SOF   = 2'd3
  } tok_kind_e;

  localparam int unsigned SYNC_BITS  = 8;
  localparam int unsigned PID_BITS   = 8;
  localparam int unsigned FIELD_BITS = 11;
  localparam int unsigned CHK_BITS   = 5;

  localparam logic [SYNC_BITS-1:0] SYNC_WORD = 8'h80;

  // Low nibble of the PID for each packet kind.
  function automatic logic [3:0] kind_code(input tok_kind_e k);
    logic [3:0] c;
    case (k)
      KIND_OUT:   c = 4'h1;
      KIND_IN:    c = 4'h9;
      KIND_SETUP: c = 4'hD;
      default:    c = 4'h5;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tokgen_pid_map.sv
module tokgen_pid_map
  import tokgen_pkg::*;
#(
  parameter int unsigned PID_W = PID_BITS
) (
  input  tok_kind_e        kind,
  output logic [PID_W-1:0] pid
);
  localparam int unsigned HALF = PID_W / 2;

  logic [HALF-1:0] code;

  always_comb begin
    code = HALF'(kind_code(kind));
    pid  = {~code, code};
  end
endmodule

// File: rtl/tokgen_field_mux.sv
module tokgen_field_mux
  import tokgen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned ENDP_W  = 4,
  parameter int unsigned FIELD_W = FIELD_BITS
) (
  input  tok_kind_e          kind,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ENDP_W-1:0]  endp,
  input  logic [FIELD_W-1:0] frame,
  output logic [FIELD_W-1:0] field
);
  // Address occupies the low bits so that it leaves first.
  always_comb begin
    if (kind == KIND_SOF) field = frame;
    else                  field = FIELD_W'({endp, addr});
  end
endmodule

// File: rtl/tokgen_crc_ser.sv
module tokgen_crc_ser #(
  parameter int unsigned         CRC_W = 5,
  parameter logic [CRC_W-1:0]    POLY  = 5'b00101,
  parameter logic [CRC_W-1:0]    SEED  = 5'b11111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_en,   // preset at packet start
  input  logic calc_en,   // absorb one field bit
  input  logic shift_en,  // move the next check bit to the top
  input  logic din,
  output logic dout       // inverted top bit of the remainder
);
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] rem_calc;
  logic             fb;

  assign fb = din ^ rem_q[CRC_W-1];

  // One term per register stage; the polynomial picks the feedback taps.
  assign rem_calc[0] = fb & POLY[0];
  for (genvar i = 1; i < CRC_W; i++) begin : g_stage
    assign rem_calc[i] = rem_q[i-1] ^ (fb & POLY[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rem_q <= SEED;
    else if (seed_en)   rem_q <= SEED;
    else if (calc_en)   rem_q <= rem_calc;
    else if (shift_en)  rem_q <= {rem_q[CRC_W-2:0], 1'b0};
  end

  assign dout = ~rem_q[CRC_W-1];

  // R6: the control pulses are mutually exclusive
  a_r6_ctrl_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({seed_en, calc_en, shift_en}) <= 1);
endmodule

// File: rtl/tokgen_seq.sv
module tokgen_seq #(
  parameter int unsigned SYNC_W  = 8,
  parameter int unsigned PID_W   = 8,
  parameter int unsigned FIELD_W = 11,
  parameter int unsigned CRC_W   = 5,
  localparam int unsigned LOAD_W = SYNC_W + PID_W + FIELD_W,
  localparam int unsigned TOTAL  = LOAD_W + CRC_W,
  localparam int unsigned CNT_W  = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LOAD_W-1:0] load_vec,
  input  logic              out_ready,
  input  logic              chk_bit,
  output logic              busy,
  output logic              out_valid,
  output logic              out_data,
  output logic              out_last,
  output logic              chk_seed,
  output logic              chk_calc,
  output logic              chk_shift,
  output logic              field_bit
);
  localparam logic [CNT_W-1:0] FIELD_AT = CNT_W'(SYNC_W + PID_W);
  localparam logic [CNT_W-1:0] CHK_AT   = CNT_W'(LOAD_W);
  localparam logic [CNT_W-1:0] LAST_AT  = CNT_W'(TOTAL - 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LOAD_W-1:0] sh_q;
  logic              fire;
  logic              in_field;
  logic              in_chk;

  assign fire     = busy_q & out_ready;
  assign in_field = (cnt_q >= FIELD_AT) && (cnt_q < CHK_AT);
  assign in_chk   = (cnt_q >= CHK_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= load_vec;
    end else if (fire) begin
      sh_q <= {1'b0, sh_q[LOAD_W-1:1]};
      if (cnt_q == LAST_AT) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_data  = in_chk ? chk_bit : sh_q[0];
  assign out_last  = busy_q && (cnt_q == LAST_AT);
  assign field_bit = sh_q[0];
  assign chk_seed  = start;
  assign chk_calc  = fire & in_field;
  assign chk_shift = fire & in_chk;

  // R7: a refused bit stays on offer unchanged
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8: accepting the final bit returns the generator to idle
  a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && !busy);

  // R9: bit 0 is on offer the cycle after a start
  a_r9_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid && (cnt_q == '0));

  // R2: the sync bits before the final one are zero
  a_r2_sync_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (cnt_q < CNT_W'(SYNC_W - 1)) |-> !out_data);

  // R1: no start is issued while a packet is in flight
  a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/tok_pkt_gen.sv
module tok_pkt_gen
  import tokgen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned ENDP_W  = 4,
  parameter int unsigned FRAME_W = FIELD_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [ENDP_W-1:0]  req_endp,
  input  logic [FRAME_W-1:0] req_frame,
  output logic               bit_valid,
  output logic               bit_data,
  output logic               bit_last,
  input  logic               bit_ready
);
  localparam int unsigned LOAD_W = SYNC_BITS + PID_BITS + FRAME_W;

  tok_kind_e          kind;
  logic [PID_BITS-1:0] pid;
  logic [FRAME_W-1:0] field;
  logic [LOAD_W-1:0]  load_vec;
  logic               busy;
  logic               start;
  logic               chk_seed, chk_calc, chk_shift, chk_bit, field_bit;

  assign kind      = tok_kind_e'(req_kind);
  assign req_ready = ~busy;
  assign start     = req_valid & ~busy;
  assign load_vec  = {field, pid, SYNC_WORD};

  tokgen_pid_map #(.PID_W(PID_BITS)) u_pid (
    .kind (kind),
    .pid  (pid)
  );

  tokgen_field_mux #(.ADDR_W(ADDR_W), .ENDP_W(ENDP_W), .FIELD_W(FRAME_W)) u_field (
    .kind  (kind),
    .addr  (req_addr),
    .endp  (req_endp),
    .frame (req_frame),
    .field (field)
  );

  tokgen_seq #(
    .SYNC_W (SYNC_BITS),
    .PID_W  (PID_BITS),
    .FIELD_W(FRAME_W),
    .CRC_W  (CHK_BITS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_vec  (load_vec),
    .out_ready (bit_ready),
    .chk_bit   (chk_bit),
    .busy      (busy),
    .out_valid (bit_valid),
    .out_data  (bit_data),
    .out_last  (bit_last),
    .chk_seed  (chk_seed),
    .chk_calc  (chk_calc),
    .chk_shift (chk_shift),
    .field_bit (field_bit)
  );

  tokgen_crc_ser #(.CRC_W(CHK_BITS)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_en  (chk_seed),
    .calc_en  (chk_calc),
    .shift_en (chk_shift),
    .din      (field_bit),
    .dout     (chk_bit)
  );

  // R1: an accepted request is followed by a busy generator
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && bit_valid);
endmodule

// File: tb/tok_pkt_gen_tb.sv
module tok_pkt_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [6:0]  req_addr = '0;
  logic [3:0]  req_endp = '0;
  logic [10:0] req_frame = '0;
  logic        bit_valid, bit_data, bit_last;
  logic        bit_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tok_pkt_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_endp(req_endp), .req_frame(req_frame),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_last(bit_last), .bit_ready(bit_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pid_of(input logic [1:0] k);
    case (k)
      2'd0: return 8'hE1;
      2'd1: return 8'h69;
      2'd2: return 8'h2D;
      default: return 8'hA5;
    endcase
  endfunction

  // Bit i of the result is the i-th transmitted bit.
  function automatic logic [31:0] expect_pkt(input logic [1:0] k, input logic [6:0] a,
                                             input logic [3:0] e, input logic [10:0] f);
    logic [31:0] v;
    logic [10:0] fld;
    logic [4:0]  rem;
    logic        top;
    fld = (k == 2'd3) ? f : {e, a};
    rem = 5'h1F;
    for (int i = 0; i < 11; i++) begin
      top = rem[4] ^ fld[i];
      rem = {rem[3:0], 1'b0};
      if (top) rem = rem ^ 5'h05;
    end
    v[7:0]   = 8'h80;
    v[15:8]  = pid_of(k);
    v[26:16] = fld;
    for (int j = 0; j < 5; j++) v[27+j] = ~rem[4-j];
    return v;
  endfunction

  task automatic send(input logic [1:0] k, input logic [6:0] a, input logic [3:0] e,
                      input logic [10:0] f, input int mode, input bit junk);
    logic [31:0] got, expv;
    int  idx, guard;
    bit  stalled, pd, pl, rdy, lastbad, holdbad, busybad;
    expv = expect_pkt(k, a, e, f);
    got = '0; idx = 0; guard = 0; stalled = 0; pd = 0; pl = 0;
    lastbad = 0; holdbad = 0; busybad = 0;
    req_kind = k; req_addr = a; req_endp = e; req_frame = f; req_valid = 1'b1;
    check(req_ready === 1'b1, "R1 ready while idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    if (junk) begin
      req_kind = ~k; req_addr = ~a; req_endp = ~e; req_frame = ~f;
    end else req_valid = 1'b0;
    check(bit_valid === 1'b1, "R9 valid after accept", {31'd0, bit_valid}, 32'd1);
    while (idx < 32 && guard < 400) begin
      guard++;
      if (req_ready !== 1'b0) busybad = 1;
      if (stalled && (bit_valid !== 1'b1 || bit_data !== pd || bit_last !== pl)) holdbad = 1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: rdy = 1'b1;
        1: rdy = lfsr[0] | lfsr[3];
        2: rdy = guard[0];
        default: rdy = lfsr[1] & lfsr[5];
      endcase
      bit_ready = rdy;
      if (bit_valid && rdy) begin
        got[idx] = bit_data;
        if (bit_last !== (idx == 31)) lastbad = 1;
        idx++;
      end
      stalled = bit_valid && !rdy;
      pd = bit_data; pl = bit_last;
      @(negedge clk);
    end
    bit_ready = 1'b0;
    req_valid = 1'b0;
    check(idx == 32, "R7 packet completed", idx, 32);
    check(bit_valid === 1'b0 && req_ready === 1'b1, "R8 idle after last",
          {30'd0, bit_valid, req_ready}, 32'd1);
    check(!lastbad, "R8 last flag only on bit 31", {31'd0, lastbad}, 0);
    check(!holdbad, "R7 stalled bit held", {31'd0, holdbad}, 0);
    check(!busybad, "R1 not ready while busy", {31'd0, busybad}, 0);
    check(got[7:0] == expv[7:0], "R2 sync byte", got[7:0], expv[7:0]);
    check(got[15:8] == expv[15:8], "R3 pid byte", got[15:8], expv[15:8]);
    if (k == 2'd3)
      check(got[26:16] == expv[26:16], "R5 frame field", got[26:16], expv[26:16]);
    else
      check(got[26:16] == expv[26:16], "R4 address and endpoint", got[26:16], expv[26:16]);
    check(got[31:27] == expv[31:27], "R6 check code", got[31:27], expv[31:27]);
    if (junk)
      check(got == expv, "R1 request during packet ignored", got, expv);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bit_valid === 1'b0 && req_ready === 1'b1, "R1 reset state",
          {30'd0, bit_valid, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_valid === 1'b0 && bit_last === 1'b0, "R8 idle after reset",
          {30'd0, bit_valid, bit_last}, 0);
    // Corner fields: all zeros and all ones for every kind.
    for (int k = 0; k < 4; k++) begin
      send(2'(k), 7'h00, 4'h0, 11'h000, 0, 1'b0);
      send(2'(k), 7'h7F, 4'hF, 11'h7FF, 1, 1'b0);
    end
    // R5: address and endpoint have no effect on SOF
    send(2'd3, 7'h55, 4'hA, 11'h123, 0, 1'b0);
    send(2'd3, 7'h2A, 4'h5, 11'h123, 2, 1'b0);
    // Sweep all addresses for each kind with mixed back-pressure.
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 128; n++) begin
        send(2'(k), 7'(n), 4'((n * 5 + k) & 15), 11'((n * 37 + k * 512 + 3) & 2047),
             n % 4, (n % 8) == 5);
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule